// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Controller

This block turns a deliberate, long, two-handed button press into a hard system reset. Two active-low push-button inputs are watched together. Only when both are held down at the same time does a hold timer run, and only when that timer reaches the selected hold interval does the block drive its reset pair. A brief press of either button, or a short overlap of both, never disturbs the system, so the same keys can also serve as ordinary interrupt sources.

Time is measured in ticks of an external slow clock-enable (for example one pulse every 100 ms). A static strap selects between a short and a long hold count. The reset lasts exactly as long as both buttons stay down: there is no stretched pulse and no reset at power-up. A supply-good input models the undervoltage detector; while it is low, the outputs are forced inactive and the buttons are ignored.

Top module: `longpress_rst_ctrl`

## Requirements
- R1: The hold count advances only on tick cycles in which both synchronised buttons are low. Releasing either button clears it, so an overlap shorter than the hold interval, or any hold of one button alone, never produces a reset.
- R2: With `hold_sel` low the reset is reached after `SHORT_TICKS` ticks of joint hold; with `hold_sel` high it takes `LONG_TICKS` ticks. `hold_sel` is a static strap.
- R3: Once the selected count is reached with both buttons still low, `reset_out` goes to 1 and `reset_n_out` goes to 0 on the same clock edge, within three clock cycles of the final tick.
- R4: Releasing either button while the reset is active deasserts both outputs within six clock cycles, with no minimum reset width.
- R5: After system reset (`rst_n` low, synchronous) the outputs are inactive (`reset_out` = 0, `reset_n_out` = 1) and no reset pulse is produced when `rst_n` is released.
- R6: `reset_n_out` is always the logical inverse of `reset_out`.
- R7: While `supply_ok` is 0, `reset_out` is 0 and `reset_n_out` is 1 in the same cycle, including when a reset was already being driven; buttons and ticks are ignored.
- R8: After `supply_ok` returns to 1, a new reset requires a fresh full hold interval, even if both buttons were held throughout the undervoltage.
- R9: Asserting `rst_n` while the reset is active deasserts both outputs on the next clock edge and clears the hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick_en | input | 1 | Single-cycle time-base enable from the slow oscillator |
| btn_a_n | input | 1 | First push-button, low when pressed (asynchronous) |
| btn_b_n | input | 1 | Second push-button, low when pressed (asynchronous) |
| hold_sel | input | 1 | Hold interval strap: 0 short, 1 long |
| supply_ok | input | 1 | Supply-good indication, 0 means undervoltage |
| reset_n_out | output | 1 | Reset output, active low |
| reset_out | output | 1 | Reset output, active high |

## Verification
A hold count that fails to clear on release would show as a reset arriving early after a re-press, after fewer ticks than the interval; the bench counts ticks exactly on each side of the threshold, so an off-by-one or a wrong strap decode shows on the tick that should or should not fire. A stuck expiry flag shows as outputs that stay active more than six cycles after a release or that return as soon as the supply recovers. The two output flops are built separately, so a mismatch between them is visible on the very cycle it occurs.

// File: rtl/lpr_pkg.sv
// Package: shared helpers for the long-press reset controller.
// Assumes hold counts are at least 1.
package lpr_pkg;

    // Pick the hold limit that the strap selects.
    function automatic int unsigned pick_limit(input logic sel,
                                               input int unsigned short_t,
                                               input int unsigned long_t);
        return sel ? long_t : short_t;
    endfunction

endpackage

// File: rtl/lpr_btn_sync.sv
// Module: lpr_btn_sync
// Two-flop synchroniser for a bank of asynchronous button lines.
// Assumes inputs are slow level signals; resets to "released" (all ones).
module lpr_btn_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        // Shift each button line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '1;
            else        chain[g] <= {chain[g][STAGES-2:0], async_in[g]};
        end
        assign sync_out[g] = chain[g][STAGES-1];
    end
endmodule

// File: rtl/lpr_hold_timer.sv
// Module: lpr_hold_timer
// Counts ticks while both buttons are held and supply is good; raises
// 'expired' when the selected limit is reached. Any release, undervoltage
// or system reset clears the count to zero.
// Assumes hold_sel is static and both limits are at least 1.
module lpr_hold_timer
    import lpr_pkg::*;
#(
    parameter int SHORT_TICKS = 75,
    parameter int LONG_TICKS  = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic both_low,
    input  logic hold_sel,
    input  logic supply_ok,
    output logic expired
);
    localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW        = $clog2(MAX_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = CW'(pick_limit(hold_sel, SHORT_TICKS, LONG_TICKS));

    // Advance, saturate or clear the hold count.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok || !both_low) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (tick_en && !expired) begin
            if (cnt_q == limit - 1'b1) begin
                cnt_q   <= limit;
                expired <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R1: a release empties the timer on the next edge.
    p_clear_on_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !both_low |=> (cnt_q == '0 && !expired));

    // R2: the count never passes the selected limit.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R8: on supply recovery the count starts again from zero.
    p_fresh_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_ok) |-> (cnt_q == '0 && !expired));
endmodule

// File: rtl/lpr_out_stage.sv
// Module: lpr_out_stage
// Registers the reset pair in two independent flops and forces both
// inactive at once while the supply is low.
// Assumes supply_ok is synchronous to clk.
module lpr_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic expired,
    input  logic both_low,
    input  logic supply_ok,
    output logic reset_out,
    output logic reset_n_out
);
    logic hi_q;
    logic lo_n_q;

    // High-true reset flop.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= expired & both_low & supply_ok;
    end

    // Low-true reset flop, built separately.
    always_ff @(posedge clk) begin
        if (!rst_n) lo_n_q <= 1'b1;
        else        lo_n_q <= ~(expired & both_low & supply_ok);
    end

    assign reset_out   = hi_q & supply_ok;
    assign reset_n_out = lo_n_q | ~supply_ok;

    // R6: the two flops stay complementary.
    p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hi_q == ~lo_n_q);

    // R3: the reset only rises after the timer has expired.
    p_rise_after_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> $past(expired));
endmodule

// File: rtl/longpress_rst_ctrl.sv
// Module: longpress_rst_ctrl (top)
// Drives a reset pair after both buttons are held for the strapped number
// of ticks; the reset lasts as long as the joint hold. No power-up pulse.
// Assumes tick_en is a one-cycle pulse and hold_sel is static.
module longpress_rst_ctrl #(
    parameter int SHORT_TICKS = 75,
    parameter int LONG_TICKS  = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic btn_a_n,
    input  logic btn_b_n,
    input  logic hold_sel,
    input  logic supply_ok,
    output logic reset_n_out,
    output logic reset_out
);
    localparam int NUM_BTN = 2;

    logic [NUM_BTN-1:0] btn_sync;
    logic               both_low;
    logic               expired;

    lpr_btn_sync #(.WIDTH(NUM_BTN), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({btn_b_n, btn_a_n}),
        .sync_out (btn_sync)
    );

    assign both_low = ~|btn_sync;

    lpr_hold_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .both_low  (both_low),
        .hold_sel  (hold_sel),
        .supply_ok (supply_ok),
        .expired   (expired)
    );

    lpr_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .expired     (expired),
        .both_low    (both_low),
        .supply_ok   (supply_ok),
        .reset_out   (reset_out),
        .reset_n_out (reset_n_out)
    );

    // R5/R9: a system reset leaves the outputs inactive on the next edge.
    p_quiet_after_reset_r5: assert property (@(posedge clk)
        !rst_n |=> (!reset_out && reset_n_out));

    // R7: undervoltage forces both outputs inactive.
    p_supply_forces_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (!reset_out && reset_n_out));
endmodule

// File: tb/longpress_rst_ctrl_tb_top.sv
module longpress_rst_ctrl_tb_top;
    localparam int NS = 5;
    localparam int NL = 9;

    logic clk = 1'b0;
    logic rst_n, tick_en, btn_a_n, btn_b_n, hold_sel, supply_ok;
    logic reset_n_out, reset_out;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    always #10 clk = ~clk;

    longpress_rst_ctrl #(.SHORT_TICKS(NS), .LONG_TICKS(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .btn_a_n(btn_a_n),
        .btn_b_n(btn_b_n), .hold_sel(hold_sel), .supply_ok(supply_ok),
        .reset_n_out(reset_n_out), .reset_out(reset_out)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare both outputs with the expected reset state.
    task automatic expect_rst(input bit active, input string req);
        n_checks++;
        if (reset_out !== active || reset_n_out !== !active) begin
            n_fail++;
            $display("FAIL %s: reset_out=%b reset_n_out=%b expected %b/%b",
                     req, reset_out, reset_n_out, active, !active);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1; wait_cyc(1);
            tick_en = 1'b0; wait_cyc(2);
        end
    endtask

    task automatic sys_reset(input bit sel);
        rst_n = 1'b0; hold_sel = sel; btn_a_n = 1'b1; btn_b_n = 1'b1;
        supply_ok = 1'b1; tick_en = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic press_both();
        btn_a_n = 1'b0; btn_b_n = 1'b0; wait_cyc(4);
    endtask

    task automatic t_reset_state();
        sys_reset(1'b0);
        expect_rst(1'b0, "R5");
        wait_cyc(5);
        expect_rst(1'b0, "R5");
    endtask

    task automatic t_short_hold();
        sys_reset(1'b0);
        press_both();
        ticks(NS - 1); wait_cyc(3);
        expect_rst(1'b0, "R2");
        ticks(1); wait_cyc(1);
        expect_rst(1'b1, "R3");
        expect_rst(1'b1, "R6");
    endtask

    task automatic t_release();
        // continues from an active reset
        btn_b_n = 1'b1; wait_cyc(6);
        expect_rst(1'b0, "R4");
        btn_b_n = 1'b0; wait_cyc(6);
        expect_rst(1'b0, "R4");
        btn_a_n = 1'b1; btn_b_n = 1'b1;
    endtask

    task automatic t_long_hold();
        sys_reset(1'b1);
        press_both();
        ticks(NS); wait_cyc(3);
        expect_rst(1'b0, "R2");
        ticks(NL - NS - 1); wait_cyc(3);
        expect_rst(1'b0, "R2");
        ticks(1); wait_cyc(1);
        expect_rst(1'b1, "R2");
        btn_a_n = 1'b1; btn_b_n = 1'b1; wait_cyc(6);
    endtask

    task automatic t_short_overlap();
        sys_reset(1'b0);
        press_both();
        ticks(NS - 1);
        btn_b_n = 1'b1; wait_cyc(4);
        btn_b_n = 1'b0; wait_cyc(4);
        ticks(NS - 1); wait_cyc(3);
        expect_rst(1'b0, "R1");
        btn_a_n = 1'b1; wait_cyc(4);
        ticks(NL + 2); wait_cyc(3);
        expect_rst(1'b0, "R1");
        btn_b_n = 1'b1;
    endtask

    task automatic t_supply();
        sys_reset(1'b0);
        press_both();
        ticks(NS); wait_cyc(1);
        expect_rst(1'b1, "R7");
        supply_ok = 1'b0; #1;
        expect_rst(1'b0, "R7");
        wait_cyc(1);
        ticks(NS + 2); wait_cyc(2);
        expect_rst(1'b0, "R7");
        supply_ok = 1'b1; wait_cyc(3);
        expect_rst(1'b0, "R8");
        ticks(NS - 1); wait_cyc(3);
        expect_rst(1'b0, "R8");
        ticks(1); wait_cyc(1);
        expect_rst(1'b1, "R8");
    endtask

    task automatic t_sys_reset_active();
        // continues from an active reset with buttons held
        rst_n = 1'b0; wait_cyc(1);
        expect_rst(1'b0, "R9");
        rst_n = 1'b1; wait_cyc(4);
        ticks(NS - 1); wait_cyc(3);
        expect_rst(1'b0, "R9");
        ticks(1); wait_cyc(1);
        expect_rst(1'b1, "R9");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; btn_a_n = 1'b1; btn_b_n = 1'b1;
        hold_sel = 1'b0; supply_ok = 1'b1;
        t_reset_state();
        t_short_hold();
        t_release();
        t_long_hold();
        t_short_overlap();
        t_supply();
        t_sys_reset_active();
        done = 1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
        end
    end
endmodule